// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A one-cycle start pulse carries the first column of the access together with the ordering (sequential or interleaved) and the length code taken from the programmed mode settings. From the next cycle on, the block presents one column per clock with a valid strobe and raises a last-beat flag on the final beat of a fixed-length burst.

The ordering and length are captured only when start is high, so the mode inputs are free to change while a burst runs. Full-page bursts walk the whole 1024-column row in ascending order and wrap around until a terminate pulse arrives. Column commands may follow each other every clock, so a new start always replaces whatever burst is in flight.

Top module: `bcol_gen`

## Requirements
- R1: While reset is held and after it is released, with no start, `valid_o` and `last_o` are 0.
- R2: One cycle after the clock edge that samples `start_i` high, `valid_o` is 1 and `col_o` equals the sampled `col_i`. A fixed-length burst then stays valid for exactly BL consecutive cycles and goes low in the cycle after its last beat, unless another start arrives.
- R3: With `ord_i`=0 (sequential), beat n presents the start column with its low log2(BL) bits replaced by (start low bits + n) modulo BL; the upper bits stay those of the start column.
- R4: With `ord_i`=1 (interleaved) and a fixed length, beat n presents the start column XOR n.
- R5: The 3-bit `len_i` code gives BL = 1, 2, 4, 8 for codes 0, 1, 2, 3; every code from 4 to 7 selects full page.
- R6: A full-page burst presents (start column + n) modulo 1024 on beat n, keeps running until terminated and never raises `last_o`; an interleaved request with a full-page code is run as sequential.
- R7: `last_o` is 1 exactly on beat BL-1 of a fixed-length burst; with BL=1 it is 1 on the single beat, in the same cycle as `valid_o`.
- R8: A terminate pulse sampled during a burst makes `valid_o` 0 from the next cycle; a terminate pulse while idle has no effect on the outputs.
- R9: A start sampled during a running burst abandons it and the next cycle presents beat 0 of the new burst; when start and terminate are sampled together, start wins.
- R10: `ord_i` and `len_i` are only used in the start cycle; changing them during a burst does not alter its column sequence or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that starts a burst |
| col_i | input | 10 | First column of the burst |
| ord_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| len_i | input | 3 | Length code: 0..3 give 1, 2, 4, 8 beats; 4..7 full page |
| term_i | input | 1 | One-cycle pulse that ends the running burst |
| col_o | output | 10 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the last of a fixed-length burst |

## Verification
The checker follows each burst on every cycle: the first column after a start, that a burst stays valid until its last beat or a terminate, that it stops after either, and that the last-beat flag falls exactly on beat BL-1 and never in full-page mode. The actual column ordering, sequential wrap within the burst boundary, interleaved XOR sequences, full-page wrap past column 1023, and the effect of changing mode inputs mid-burst are shown only by the bench scenarios, which compare every beat against an independently computed sequence.

// File: rtl/bcol_pkg.sv
package bcol_pkg;
  // burst ordering selector
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_IL  = 1'b1
  } bcol_ord_e;

  // width of the length code; codes at or above 2**(LEN_CODE_W-1) mean full page
  localparam int LEN_CODE_W = 3;
  localparam int COL_BITS   = 10;
endpackage

// File: rtl/bcol_rst_sync.sv
module bcol_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bcol_map.sv
module bcol_map #(
  parameter int COL_W = 10,
  parameter int LG_W  = 2
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic             il,
  input  logic             full,
  input  logic [LG_W-1:0]  lg,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] sum;

  always_comb begin
    mask = full ? {COL_W{1'b1}} : ((COL_W'(1) << lg) - COL_W'(1));
    sum  = base + beat;
    if (il && !full) col = base ^ (beat & mask);
    else             col = (base & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/bcol_seq_ctrl.sv
module bcol_seq_ctrl #(
  parameter int COL_W = 10,
  parameter int LG_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             term,
  input  logic             full,
  input  logic [LG_W-1:0]  lg,
  output logic             act,
  output logic [COL_W-1:0] beat,
  output logic             last
);
  logic             act_q, act_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic             en;
  logic [COL_W-1:0] final_beat;

  assign final_beat = (COL_W'(1) << lg) - COL_W'(1);
  assign last       = act_q && !full && (beat_q == final_beat);
  assign en         = start || act_q;

  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    if (start) begin
      act_d  = 1'b1;
      beat_d = '0;
    end else if (act_q) begin
      if (term || last) begin
        act_d  = 1'b0;
        beat_d = '0;
      end else begin
        beat_d = beat_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
    end else if (en) begin
      act_q  <= act_d;
      beat_q <= beat_d;
    end
  end

  assign act  = act_q;
  assign beat = beat_q;
endmodule

// File: rtl/bcol_gen.sv
module bcol_gen
  import bcol_pkg::*;
#(
  parameter int COL_W = COL_BITS,
  parameter int LEN_W = LEN_CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ord_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int LG_W = LEN_W - 1;
  localparam logic [LEN_W-1:0] FULL_CODE = LEN_W'(1) << LG_W;

  logic             rst_s_n;
  logic             full_in;
  logic [LG_W-1:0]  lg_in;
  logic [COL_W-1:0] base_q;
  logic             il_q, full_q;
  logic [LG_W-1:0]  lg_q;
  logic             act;
  logic [COL_W-1:0] beat;
  logic             last;

  bcol_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  // decode the length code; full page forces sequential ordering
  assign full_in = (len_i >= FULL_CODE);
  assign lg_in   = full_in ? '0 : len_i[LG_W-1:0];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      base_q <= '0;
      il_q   <= 1'b0;
      full_q <= 1'b0;
      lg_q   <= '0;
    end else if (start_i) begin
      base_q <= col_i;
      il_q   <= (bcol_ord_e'(ord_i) == ORD_IL) && !full_in;
      full_q <= full_in;
      lg_q   <= lg_in;
    end
  end

  bcol_seq_ctrl #(.COL_W(COL_W), .LG_W(LG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .start(start_i), .term(term_i),
    .full(full_q), .lg(lg_q), .act(act), .beat(beat), .last(last)
  );

  bcol_map #(.COL_W(COL_W), .LG_W(LG_W)) u_map (
    .base(base_q), .beat(beat), .il(il_q), .full(full_q), .lg(lg_q),
    .col(col_o)
  );

  assign valid_o = act;
  assign last_o  = last;
endmodule

// File: rtl/bcol_chk.sv
module bcol_chk #(
  parameter int COL_W = 10,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic             ord_i,
  input logic [LEN_W-1:0] len_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  localparam int LG_W = LEN_W - 1;
  localparam logic [LEN_W-1:0] FULL_CODE = LEN_W'(1) << LG_W;

  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] fin_q;
  logic             full_q;

  // beat index tracker built from the ports alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fin_q  <= '0;
      full_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      full_q <= (len_i >= FULL_CODE);
      fin_q  <= (COL_W'(1) << len_i[LG_W-1:0]) - COL_W'(1);
    end else if (valid_o) begin
      cnt_q  <= cnt_q + COL_W'(1);
    end
  end

  a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(col_i)));

  a_r2_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !term_i && !start_i) |=> valid_o);

  a_r2_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !start_i) |=> !valid_o);

  a_r7_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (last_o == (!full_q && cnt_q == fin_q)));

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r6_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i >= FULL_CODE) |=> !last_o);
endmodule

bind bcol_gen bcol_chk #(.COL_W(COL_W), .LEN_W(LEN_W)) u_bcol_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
  .ord_i(ord_i), .len_i(len_i), .term_i(term_i), .col_o(col_o),
  .valid_o(valid_o), .last_o(last_o)
);

// File: tb/bcol_gen_tb_top.sv
module bcol_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, ord_i, term_i;
  logic [9:0] col_i;
  logic [2:0] len_i;
  logic [9:0] col_o;
  logic       valid_o, last_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bcol_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .ord_i(ord_i), .len_i(len_i), .term_i(term_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o)
  );

  function automatic logic [9:0] ref_col(int base, int n, bit il, int code);
    int bl;
    if (code >= 4) return 10'((base + n) % 1024);
    bl = 1 << code;
    if (il) return 10'(base ^ n);
    return 10'((base - base % bl) + ((base % bl + n) % bl));
  endfunction

  task automatic expect_beat(input string rq, input logic [9:0] ec, input bit el);
    checks++;
    if (!(valid_o === 1'b1 && col_o === ec && last_o === el)) begin
      errors++;
      $display("FAIL %s: valid=%b col=%h last=%b expected valid=1 col=%h last=%b",
               rq, valid_o, col_o, last_o, ec, el);
    end
  endtask

  task automatic expect_idle(input string rq);
    checks++;
    if (!(valid_o === 1'b0 && last_o === 1'b0)) begin
      errors++;
      $display("FAIL %s: valid=%b last=%b expected valid=0 last=0",
               rq, valid_o, last_o);
    end
  endtask

  task automatic launch(input logic [9:0] c, input bit il, input logic [2:0] code);
    @(negedge clk);
    start_i = 1'b1; col_i = c; ord_i = il; len_i = code;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // R2 R3 R4 R5 R7: complete fixed-length burst
  task automatic t_burst(input string rq, input logic [9:0] c, input bit il,
                         input int code);
    int bl = 1 << code;
    launch(c, il, 3'(code));
    for (int n = 0; n < bl; n++) begin
      expect_beat(rq, ref_col(c, n, il, code), n == bl - 1);
      @(negedge clk);
    end
    expect_idle({rq, " end"});
  endtask

  // R6 R8: full page wraps past 1023, interleave demoted, stopped by term
  task automatic t_full(input logic [2:0] code);
    launch(10'h3FD, 1'b1, code);
    for (int n = 0; n < 6; n++) begin
      expect_beat("R6 full page", ref_col(10'h3FD, n, 1'b0, 4), 1'b0);
      if (n < 5) @(negedge clk);
    end
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    expect_idle("R8 term ends full page");
  endtask

  // R8: terminate while idle
  task automatic t_term_idle;
    @(negedge clk);
    term_i = 1'b1; col_i = 10'h2AA;
    @(negedge clk);
    expect_idle("R8 term while idle");
    @(negedge clk);
    term_i = 1'b0;
    expect_idle("R8 term while idle 2");
  endtask

  // R9: restart mid-burst with simultaneous terminate
  task automatic t_restart;
    launch(10'h100, 1'b0, 3'd3);
    for (int n = 0; n < 3; n++) begin
      expect_beat("R9 first burst", ref_col(10'h100, n, 1'b0, 3), 1'b0);
      if (n < 2) @(negedge clk);
    end
    start_i = 1'b1; term_i = 1'b1; col_i = 10'h205; ord_i = 1'b1; len_i = 3'd2;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      expect_beat("R9 restarted burst", ref_col(10'h205, n, 1'b1, 2), n == 3);
      @(negedge clk);
    end
    expect_idle("R9 restarted end");
  endtask

  // R10: mode inputs changed mid-burst are ignored
  task automatic t_latch;
    launch(10'h007, 1'b0, 3'd2);
    ord_i = 1'b1; len_i = 3'd0;
    for (int n = 0; n < 4; n++) begin
      expect_beat("R10 mode held", ref_col(10'h007, n, 1'b0, 2), n == 3);
      @(negedge clk);
    end
    expect_idle("R10 length held");
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; term_i = 1'b0; ord_i = 1'b0;
    col_i = '0; len_i = '0;
    repeat (3) @(negedge clk);
    expect_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_idle("R1 after reset");

    t_burst("R3 seq BL8 wrap", 10'h3FD, 1'b0, 3);
    t_burst("R4 il BL8", 10'h2A5, 1'b1, 3);
    t_burst("R3 seq BL4", 10'h013, 1'b0, 2);
    t_burst("R4 il BL4", 10'h0F2, 1'b1, 2);
    t_burst("R5 seq BL2", 10'h1FF, 1'b0, 1);
    t_burst("R7 BL1", 10'h155, 1'b0, 0);
    t_burst("R7 il BL1", 10'h0AB, 1'b1, 0);
    t_full(3'd4);
    t_full(3'd6);
    t_term_idle();
    t_restart();
    t_latch();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule